// File: doc/BRIEF.md
# Vectored Interrupt Handshake Controller

This block sits on the controller side of a vectored interrupt port. It watches a set of level-sensitive request lines. Each line has an enable bit, a programmable priority and a programmable vector address. The block drives an active-low interrupt line to a processor. When the processor acknowledges, it hands over the word-aligned vector address of the winning source, using a four-phase handshake built on an acknowledge input and an address-valid strobe.

The vector is chosen late. While the acknowledge is travelling through the synchronizer and the strobe is still low, the vector bus follows the best pending source, so a more urgent request that arrives in that window still wins. Once the strobe is high, the vector is frozen. When the acknowledge falls, the priority of the source that was vectored is pushed onto a service stack. From then on, only strictly more urgent requests can raise the interrupt again. A one-cycle end-of-service input pops the stack.

Priority value 0 is the most urgent. An empty stack means that no source is in service.

Top module: `vic_handshake_ctrl`

## Requirements
- R1: After reset, `irq_n` is 1, `vec_valid` is 0, `stack_ovf` and `stack_unf` are 0, and the service stack is empty.
- R2: `irq_n` goes low on the clock edge after an enabled request appears whose priority value is numerically below the current service level. An empty stack lets every priority through. Requests with their `irq_en` bit at 0, and requests whose priority value is equal to or above the level, leave `irq_n` at 1.
- R3: Among pending sources with equal priority value, the source with the lowest index is vectored.
- R4: With `ack_in` held high, `vec_valid` rises on the (SYNC_STAGES+2)-th rising edge after `ack_in` rises. At that point `vec_addr` carries the vector of the best outranking source, including a source that was raised in the same cycle as the acknowledge. `vec_addr` holds address bits 31 down to 2, taken from field i of `vec_cfg`, which is bits [i*30 +: 30].
- R5: While `vec_valid` is high, `vec_addr` does not change, even when a more urgent request arrives.
- R6: When the synchronized acknowledge is seen low while `vec_valid` is high, `vec_valid` falls on that edge and the vectored priority is pushed. On the same edge, `irq_n` returns to 1 unless another pending request outranks the pushed priority, in which case it stays 0.
- R7: A one-cycle `eos_pulse` pops the top of the stack. On that edge, `irq_n` goes low again if a pending request outranks the restored level.
- R8: A push when the stack already holds STACK_DEPTH entries leaves the stack unchanged and gives a one-cycle `stack_ovf` pulse. A pop of an empty stack gives a one-cycle `stack_unf` pulse.
- R9: The priority of source i is field [i*PRIO_W +: PRIO_W] of `prio_cfg`, an unsigned value, with 0 as the most urgent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NSRC | Level request lines |
| irq_en | input | NSRC | Per-source enable |
| prio_cfg | input | NSRC*PRIO_W | Packed priority table |
| vec_cfg | input | NSRC*ADDR_W | Packed vector table (address bits 31:2) |
| ack_in | input | 1 | Processor acknowledge, may be asynchronous |
| eos_pulse | input | 1 | End-of-service, pops the service stack |
| irq_n | output | 1 | Active-low interrupt to the processor |
| vec_addr | output | ADDR_W | Vector address bits 31:2 |
| vec_valid | output | 1 | Vector address valid strobe |
| stack_ovf | output | 1 | Push into a full stack |
| stack_unf | output | 1 | Pop of an empty stack |

## Verification
Two situations are hard to reach from the ports. The first is the short window between the acknowledge being raised and the strobe rising. The bench raises a more urgent request on the same cycle as the acknowledge, and checks both the latency of the strobe and which vector the bus settles on. The second is overflow of the service stack. Priorities strictly decrease up the stack, so overflow cannot happen at the default depth. The bench therefore builds the block with a shallow stack, nests five handshakes with falling priority values, and then pops one more time than it pushed.

// File: rtl/ivh_pkg.sv
package ivh_pkg;
  typedef enum logic [1:0] {HS_IDLE, HS_SEL, HS_VALID} hs_state_t;

  // Smaller value is more urgent; level 2**PRIO_W means nothing in service.
  function automatic logic outranks(input logic [7:0] prio, input logic [7:0] level);
    return prio < level;
  endfunction
endpackage

// File: rtl/ivh_sync.sv
module ivh_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int N = (STAGES < 1) ? 1 : STAGES;
  logic [W-1:0] st [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < N; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[N-1];
endmodule

// File: rtl/ivh_arbiter.sv
module ivh_arbiter #(
  parameter int NSRC   = 16,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          req,
  input  logic [NSRC-1:0]          en,
  input  logic [NSRC*PRIO_W-1:0]   prio_cfg,
  output logic                     best_valid,
  output logic [IDX_W-1:0]         best_idx,
  output logic [PRIO_W-1:0]        best_prio
);
  function automatic logic [PRIO_W-1:0] prio_of(input int i);
    return prio_cfg[i*PRIO_W +: PRIO_W];
  endfunction

  // Strict compare keeps the first (lowest-index) source on a tie.
  always_comb begin
    best_valid = 1'b0;
    best_idx   = '0;
    best_prio  = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && en[i] && (!best_valid || prio_of(i) < best_prio)) begin
        best_valid = 1'b1;
        best_idx   = IDX_W'(i);
        best_prio  = prio_of(i);
      end
    end
  end

  assert_winner_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    best_valid |-> (req[best_idx] && en[best_idx]));
endmodule

// File: rtl/ivh_prio_stack.sv
module ivh_prio_stack #(
  parameter int PRIO_W = 4,
  parameter int DEPTH  = 16,
  localparam int LVL_W = PRIO_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop,
  output logic [LVL_W-1:0]  level,
  output logic [LVL_W-1:0]  level_next,
  output logic              ovf,
  output logic              unf
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [LVL_W-1:0] NONE = LVL_W'(1 << PRIO_W);

  logic [PRIO_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  cnt, cnt_after_pop, cnt_n;
  logic              empty, full, do_pop, do_push;

  assign empty         = (cnt == '0);
  assign full          = (cnt == CNT_W'(DEPTH));
  assign do_pop        = pop && !empty;
  assign cnt_after_pop = cnt - CNT_W'(do_pop);
  assign do_push       = push && (cnt_after_pop != CNT_W'(DEPTH));
  assign cnt_n         = cnt_after_pop + CNT_W'(do_push);

  always_comb begin
    if (empty) level = NONE;
    else       level = {1'b0, mem[IDX_W'(cnt - 1'b1)]};
    if (do_push)           level_next = {1'b0, push_prio};
    else if (cnt_n == '0)  level_next = NONE;
    else                   level_next = {1'b0, mem[IDX_W'(cnt_n - 1'b1)]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      cnt <= cnt_n;
      ovf <= push && !do_push;
      unf <= pop && empty;
      if (do_push) mem[IDX_W'(cnt_after_pop)] <= push_prio;
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt == $past(cnt)));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (cnt == '0));
endmodule

// File: rtl/vic_handshake_ctrl.sv
module vic_handshake_ctrl
  import ivh_pkg::*;
#(
  parameter int NSRC        = 16,
  parameter int PRIO_W      = 4,
  parameter int ADDR_W      = 30,
  parameter int STACK_DEPTH = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit REQ_SYNC    = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          irq_req,
  input  logic [NSRC-1:0]          irq_en,
  input  logic [NSRC*PRIO_W-1:0]   prio_cfg,
  input  logic [NSRC*ADDR_W-1:0]   vec_cfg,
  input  logic                     ack_in,
  input  logic                     eos_pulse,
  output logic                     irq_n,
  output logic [ADDR_W-1:0]        vec_addr,
  output logic                     vec_valid,
  output logic                     stack_ovf,
  output logic                     stack_unf
);
  localparam int IDX_W = $clog2(NSRC);
  localparam int LVL_W = PRIO_W + 1;

  logic [NSRC-1:0]   req_s;
  logic              ack_s;
  logic              best_valid;
  logic [IDX_W-1:0]  best_idx;
  logic [PRIO_W-1:0] best_prio, held_prio;
  logic [LVL_W-1:0]  level, level_next;
  logic              above_now, above_next, push_ev;
  logic [ADDR_W-1:0] best_vec;
  hs_state_t         state;

  generate
    if (REQ_SYNC) begin : g_req_sync
      ivh_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .d(irq_req), .q(req_s));
    end else begin : g_req_direct
      assign req_s = irq_req;
    end
  endgenerate

  ivh_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_in), .q(ack_s));

  ivh_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_s), .en(irq_en), .prio_cfg(prio_cfg),
    .best_valid(best_valid), .best_idx(best_idx), .best_prio(best_prio));

  assign push_ev = (state == HS_VALID) && !ack_s;

  ivh_prio_stack #(.PRIO_W(PRIO_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push_ev), .push_prio(held_prio),
    .pop(eos_pulse), .level(level), .level_next(level_next),
    .ovf(stack_ovf), .unf(stack_unf));

  assign above_now  = best_valid && outranks(8'(best_prio), 8'(level));
  assign above_next = best_valid && outranks(8'(best_prio), 8'(level_next));
  assign best_vec   = vec_cfg[best_idx*ADDR_W +: ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= HS_IDLE;
      irq_n     <= 1'b1;
      vec_addr  <= '0;
      vec_valid <= 1'b0;
      held_prio <= '0;
    end else begin
      irq_n <= !above_next;
      case (state)
        HS_IDLE: begin
          if (above_now) begin
            vec_addr  <= best_vec;
            held_prio <= best_prio;
          end
          if (ack_s && !irq_n) state <= HS_SEL;
        end
        HS_SEL: begin
          if (above_now) begin
            vec_addr  <= best_vec;
            held_prio <= best_prio;
          end
          vec_valid <= 1'b1;
          state     <= HS_VALID;
        end
        HS_VALID: begin
          if (!ack_s) begin
            vec_valid <= 1'b0;
            state     <= HS_IDLE;
          end
        end
        default: state <= HS_IDLE;
      endcase
    end
  end

  assert_valid_follows_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> $past(ack_s, 2));
  assert_vec_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && $past(vec_valid)) |-> $stable(vec_addr));
  assert_drop_on_ack_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vec_valid) |-> !$past(ack_s));
endmodule

// File: tb/sim_vic_handshake_ctrl.sv
module sim_vic_handshake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 16;
  localparam int PW   = 4;
  localparam int AW   = 30;
  localparam int DEPTH = 4;
  localparam int SYNC = 2;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] irq_req = '0, irq_en = '1;
  logic [NSRC*PW-1:0] prio_cfg = '0;
  logic [NSRC*AW-1:0] vec_cfg = '0;
  logic ack_in = 0, eos_pulse = 0;
  logic irq_n, vec_valid, stack_ovf, stack_unf;
  logic [AW-1:0] vec_addr;

  int checks = 0, fails = 0;
  bit done = 0;
  int prio [NSRC];

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_handshake_ctrl #(.NSRC(NSRC), .PRIO_W(PW), .ADDR_W(AW),
    .STACK_DEPTH(DEPTH), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
    .prio_cfg(prio_cfg), .vec_cfg(vec_cfg), .ack_in(ack_in),
    .eos_pulse(eos_pulse), .irq_n(irq_n), .vec_addr(vec_addr),
    .vec_valid(vec_valid), .stack_ovf(stack_ovf), .stack_unf(stack_unf));

  function automatic logic [AW-1:0] exp_vec(input int i);
    return 30'h0ABC000 + AW'(i * 64);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_prio();
    for (int i = 0; i < NSRC; i++) prio_cfg[i*PW +: PW] = PW'(prio[i]);
  endtask

  task automatic eos_once();
    eos_pulse = 1; tick(1); eos_pulse = 0;
  endtask

  // Full handshake; late_mask is raised together with the acknowledge.
  task automatic hs(input logic [NSRC-1:0] late_mask, output logic [AW-1:0] v,
                    output int lat, output bit ovf, output bit irq_after);
    int n;
    ack_in = 1;
    irq_req = irq_req | late_mask;
    lat = 0;
    do begin tick(1); lat++; end while (!vec_valid && lat < 20);
    v = vec_addr;
    ack_in = 0;
    n = 0;
    do begin tick(1); n++; end while (vec_valid && n < 20);
    ovf = stack_ovf;
    irq_after = irq_n;
    if (n >= 20) check(0, "R6", "strobe stuck high", 1, 0);
  endtask

  task automatic t_reset();
    check(irq_n === 1'b1, "R1", "irq_n", irq_n, 1);
    check(vec_valid === 1'b0, "R1", "vec_valid", vec_valid, 0);
    check(stack_ovf === 1'b0 && stack_unf === 1'b0, "R1", "flags",
          {stack_ovf, stack_unf}, 0);
  endtask

  task automatic t_basic();
    logic [AW-1:0] v; int lat; bit ovf, ia;
    prio[3] = 8; load_prio();
    irq_req = 16'h0008; tick(1);
    check(irq_n == 0, "R2", "irq after request", irq_n, 0);
    hs('0, v, lat, ovf, ia);
    check(v == exp_vec(3), "R4", "basic vector", v, exp_vec(3));
    check(lat == SYNC + 2, "R4", "strobe latency", lat, SYNC + 2);
    check(ia == 1, "R6", "irq released, equal prio masked", ia, 1);
    eos_once();
    check(irq_n == 0, "R7", "irq back after pop", irq_n, 0);
    irq_req = '0; tick(1);
    check(irq_n == 1, "R2", "irq idle", irq_n, 1);
  endtask

  task automatic t_tie();
    logic [AW-1:0] v; int lat; bit ovf, ia;
    prio[2] = 6; prio[5] = 6; load_prio();
    irq_req = 16'h0024; tick(1);
    hs('0, v, lat, ovf, ia);
    check(v == exp_vec(2), "R3", "tie picks low index", v, exp_vec(2));
    check(ia == 1, "R6", "equal prio stays masked", ia, 1);
    irq_req = '0; eos_once(); tick(1);
  endtask

  task automatic t_late();
    logic [AW-1:0] v; int lat; bit ovf, ia;
    prio[4] = 9; prio[7] = 3; load_prio();
    irq_req = 16'h0010; tick(1);
    check(irq_n == 0, "R2", "irq for src4", irq_n, 0);
    hs(16'h0080, v, lat, ovf, ia);
    check(v == exp_vec(7), "R4", "late urgent source wins", v, exp_vec(7));
    check(lat == SYNC + 2, "R4", "latency with late source", lat, SYNC + 2);
    check(ia == 1, "R6", "src4 below level 3", ia, 1);
    irq_req = 16'h0010;
    eos_once();
    check(irq_n == 0, "R7", "src4 reasserts after pop", irq_n, 0);
    hs('0, v, lat, ovf, ia);
    check(v == exp_vec(4), "R4", "src4 vector", v, exp_vec(4));
    irq_req = '0; eos_once(); tick(1);
  endtask

  task automatic t_freeze();
    logic [AW-1:0] v; int lat, n; bit ovf, ia;
    prio[9] = 10; prio[0] = 0; load_prio();
    irq_req = 16'h0200; tick(1);
    ack_in = 1; n = 0;
    do begin tick(1); n++; end while (!vec_valid && n < 20);
    irq_req = 16'h0201;
    tick(3);
    check(vec_addr == exp_vec(9), "R5", "vector frozen", vec_addr, exp_vec(9));
    check(vec_valid == 1, "R5", "strobe held", vec_valid, 1);
    ack_in = 0; n = 0;
    do begin tick(1); n++; end while (vec_valid && n < 20);
    check(irq_n == 0, "R6", "outranking request keeps irq low", irq_n, 0);
    hs('0, v, lat, ovf, ia);
    check(v == exp_vec(0), "R4", "nested vector", v, exp_vec(0));
    check(ia == 1, "R6", "nothing outranks level 0", ia, 1);
    irq_req = '0; eos_once(); eos_once(); tick(1);
  endtask

  task automatic t_disabled();
    prio[11] = 1; load_prio();
    irq_en = ~16'h0800; irq_req = 16'h0800; tick(2);
    check(irq_n == 1, "R2", "disabled source ignored", irq_n, 1);
    irq_req = '0; irq_en = '1; tick(1);
  endtask

  task automatic t_overflow();
    logic [AW-1:0] v; int lat; bit ovf, ia;
    for (int k = 1; k <= 5; k++) prio[k] = 14 - 2*k;
    load_prio();
    for (int k = 1; k <= 5; k++) begin
      irq_req = irq_req | NSRC'(1 << k); tick(1);
      hs('0, v, lat, ovf, ia);
      check(v == exp_vec(k), "R9", "nested vector by prio", v, exp_vec(k));
      check(ovf == (k == 5), "R8", "overflow pulse", ovf, k == 5);
    end
    check(ia == 0, "R8", "stack unchanged on overflow", ia, 0);
    tick(1);
    check(stack_ovf == 0, "R8", "overflow one cycle", stack_ovf, 0);
    irq_req = '0;
    for (int k = 0; k < DEPTH; k++) begin
      eos_once();
      check(stack_unf == 0, "R8", "no underflow while filled", stack_unf, 0);
    end
    eos_once();
    check(stack_unf == 1, "R8", "underflow pulse", stack_unf, 1);
    tick(1);
    check(stack_unf == 0, "R8", "underflow one cycle", stack_unf, 0);
  endtask

  initial begin
    for (int i = 0; i < NSRC; i++) begin
      prio[i] = 15;
      vec_cfg[i*AW +: AW] = exp_vec(i);
    end
    load_prio();
    tick(2);
    t_reset();
    rst_n = 1;
    tick(2);
    t_basic();
    t_tie();
    t_late();
    t_freeze();
    t_disabled();
    t_overflow();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule